// File: doc/BRIEF.md
# Memory Sleep Mode Controller

This block sequences a synchronous memory into and out of a low-power sleep state. A sleep request arrives on an input with no timing relation to the clock. The block synchronises it, and then steps through a fixed entry phase into a sleep state in which a power-gating flag is raised. When the request falls, the block runs a fixed exit phase and then a recovery window before it allows accesses again. New accesses are allowed only while the controller is fully active.

Around these transitions the block watches for three usage faults. The first is an access still in flight when entry begins: it is reported with a one-cycle abort pulse. The second is a sleep request taken while the memory is still selected. The third is select or address-strobe activity during the wake-up window. The last two set sticky flags that only a reset clears. The block has no data path, so all of its pins are plain level control and status signals with no handshake. The stored contents are never touched by any transition. The only effect on the core is the power-gating flag, and the array keeps its contents while that flag is high.

Top module: `mem_sleep_ctrl`

## Requirements
- R1: While `rst` is high at a rising edge, the block returns to ACTIVE (`state_o` = 0), drives `access_en` = 1 and `pwr_gate` = 0, and clears `access_abort`, `sel_err` and `recov_viol`.
- R2: `sleep_req_async` passes through a SYNC_STAGES-flop synchroniser. A request first sampled high at edge k moves `state_o` out of ACTIVE at edge k+SYNC_STAGES.
- R3: The state encoding on `state_o` is ACTIVE=0, ENTERING=1, SLEEP=2, EXITING=3, RECOVERY=4. ENTERING lasts exactly ENTER_CYCLES clocks (default 2) and is always followed by SLEEP.
- R4: SLEEP is held while the synchronised request stays high. When it falls, the block goes to EXITING, which lasts exactly EXIT_CYCLES clocks (default 2) and is followed by RECOVERY.
- R5: RECOVERY lasts exactly RECOV_CYCLES clocks and is followed by ACTIVE.
- R6: `access_en` is high only in ACTIVE, and `pwr_gate` is high only in SLEEP.
- R7: If `access_busy` is high on the edge where ACTIVE turns into ENTERING, `access_abort` is high for exactly the following cycle.
- R8: If any of `chip_sel`, `astb_proc` or `astb_ctrl` is high on the edge where ACTIVE turns into ENTERING, `sel_err` is set and stays set until reset.
- R9: Any of `chip_sel`, `astb_proc` or `astb_ctrl` high on an edge during EXITING or RECOVERY sets `recov_viol`, which stays set until reset.
- R10: With the request held low, the block stays in ACTIVE. Select and strobe activity there sets no flag.
- R11: A request that falls during ENTERING does not shorten entry. The block still reaches SLEEP and then leaves through EXITING.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sleep_req_async | input | 1 | Sleep request, asynchronous to clk, active high |
| chip_sel | input | 1 | High when any chip enable of the memory is asserted |
| astb_proc | input | 1 | High when the processor-side address strobe is asserted |
| astb_ctrl | input | 1 | High when the controller-side address strobe is asserted |
| access_busy | input | 1 | High while an access is in flight |
| state_o | output | 3 | Current state (encoding in R3) |
| pwr_gate | output | 1 | Power-gating flag for the memory core |
| access_en | output | 1 | New accesses allowed |
| access_abort | output | 1 | One-cycle pulse: the in-flight access is invalid |
| sel_err | output | 1 | Sticky: sleep was requested while the memory was selected |
| recov_viol | output | 1 | Sticky: select or strobe activity during the wake window |

## Verification
`state_o`, `access_en` and `pwr_gate` are decoded straight from the state register. A wrong transition therefore shows at the ports in the same cycle it happens, and the bench compares these outputs against its model after every edge. A phase counter that is off by one shows up as an ENTERING, EXITING or RECOVERY dwell that is one clock too long or too short, and is seen when that phase ends. A dropped or spurious fault flag stays wrong on the port until the next reset, because both error flags are sticky. A synchroniser of the wrong depth shifts every later state change by a whole cycle.

// File: rtl/mslp_pkg.sv
package mslp_pkg;

  typedef enum logic [2:0] {
    ST_ACTIVE = 3'd0,
    ST_ENTER  = 3'd1,
    ST_SLEEP  = 3'd2,
    ST_EXIT   = 3'd3,
    ST_RECOV  = 3'd4
  } mslp_state_e;

endpackage

// File: rtl/mslp_sync.sv
module mslp_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d_async,
  output logic q
);

  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= d_async;
      end
    end else begin : g_multi
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-2:0], d_async};
      end
    end
  endgenerate

  assign q = chain[STAGES-1];

endmodule

// File: rtl/mslp_seq.sv
module mslp_seq
  import mslp_pkg::*;
#(
  parameter int ENTER_CYCLES = 2,
  parameter int EXIT_CYCLES  = 2,
  parameter int RECOV_CYCLES = 6
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        req_s,
  output mslp_state_e state
);

  localparam int MAXLEN = (ENTER_CYCLES > EXIT_CYCLES)
                        ? ((ENTER_CYCLES > RECOV_CYCLES) ? ENTER_CYCLES : RECOV_CYCLES)
                        : ((EXIT_CYCLES > RECOV_CYCLES) ? EXIT_CYCLES : RECOV_CYCLES);
  localparam int CW = (MAXLEN > 1) ? $clog2(MAXLEN) : 1;
  localparam logic [CW-1:0] ENT_LAST = CW'(ENTER_CYCLES - 1);
  localparam logic [CW-1:0] EXI_LAST = CW'(EXIT_CYCLES - 1);
  localparam logic [CW-1:0] REC_LAST = CW'(RECOV_CYCLES - 1);

  mslp_state_e nxt;
  logic [CW-1:0] cnt;
  logic timed;

  always_comb begin
    nxt = state;
    unique case (state)
      ST_ACTIVE: if (req_s)           nxt = ST_ENTER;
      ST_ENTER:  if (cnt == ENT_LAST) nxt = ST_SLEEP;
      ST_SLEEP:  if (!req_s)          nxt = ST_EXIT;
      ST_EXIT:   if (cnt == EXI_LAST) nxt = ST_RECOV;
      ST_RECOV:  if (cnt == REC_LAST) nxt = ST_ACTIVE;
      default:                        nxt = ST_ACTIVE;
    endcase
  end

  assign timed = (state == ST_ENTER) || (state == ST_EXIT) || (state == ST_RECOV);

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_ACTIVE;
      cnt   <= '0;
    end else begin
      state <= nxt;
      if (nxt != state || !timed) cnt <= '0;
      else                        cnt <= cnt + 1'b1;
    end
  end

endmodule

// File: rtl/mslp_guard.sv
module mslp_guard
  import mslp_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  mslp_state_e state,
  input  logic        req_s,
  input  logic        busy,
  input  logic        sel_any,
  output logic        abort,
  output logic        sel_err,
  output logic        viol
);

  logic entering_now;
  logic wake_window;

  assign entering_now = (state == ST_ACTIVE) && req_s;
  assign wake_window  = (state == ST_EXIT) || (state == ST_RECOV);

  always_ff @(posedge clk) begin
    if (rst) begin
      abort   <= 1'b0;
      sel_err <= 1'b0;
      viol    <= 1'b0;
    end else begin
      abort <= entering_now && busy;
      if (entering_now && sel_any) sel_err <= 1'b1;
      if (wake_window && sel_any)  viol    <= 1'b1;
    end
  end

endmodule

// File: rtl/mem_sleep_ctrl.sv
module mem_sleep_ctrl
  import mslp_pkg::*;
#(
  parameter int SYNC_STAGES  = 2,
  parameter int ENTER_CYCLES = 2,
  parameter int EXIT_CYCLES  = 2,
  parameter int RECOV_CYCLES = 6
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       sleep_req_async,
  input  logic       chip_sel,
  input  logic       astb_proc,
  input  logic       astb_ctrl,
  input  logic       access_busy,
  output logic [2:0] state_o,
  output logic       pwr_gate,
  output logic       access_en,
  output logic       access_abort,
  output logic       sel_err,
  output logic       recov_viol
);

  logic        req_s;
  logic        sel_any;
  mslp_state_e state;

  assign sel_any = chip_sel | astb_proc | astb_ctrl;

  mslp_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .d_async (sleep_req_async),
    .q       (req_s)
  );

  mslp_seq #(
    .ENTER_CYCLES (ENTER_CYCLES),
    .EXIT_CYCLES  (EXIT_CYCLES),
    .RECOV_CYCLES (RECOV_CYCLES)
  ) u_seq (
    .clk   (clk),
    .rst   (rst),
    .req_s (req_s),
    .state (state)
  );

  mslp_guard u_guard (
    .clk     (clk),
    .rst     (rst),
    .state   (state),
    .req_s   (req_s),
    .busy    (access_busy),
    .sel_any (sel_any),
    .abort   (access_abort),
    .sel_err (sel_err),
    .viol    (recov_viol)
  );

  assign state_o   = state;
  assign pwr_gate  = (state == ST_SLEEP);
  assign access_en = (state == ST_ACTIVE);

endmodule

// File: rtl/mslp_chk.sv
module mslp_chk (
  input logic       clk,
  input logic       rst,
  input logic [2:0] state_o,
  input logic       pwr_gate,
  input logic       access_en,
  input logic       access_abort,
  input logic       sel_err,
  input logic       recov_viol
);

  // R1: reset state visible one edge after reset is sampled
  a_r1_reset_state: assert property (@(posedge clk)
    $past(rst) |-> (state_o == 3'd0 && access_en && !pwr_gate
                    && !access_abort && !sel_err && !recov_viol));

  // R3: SLEEP is entered only after two cycles of ENTERING
  a_r3_entry_dwell: assert property (@(posedge clk) disable iff (rst)
    (state_o == 3'd2 && $past(state_o) != 3'd2)
      |-> ($past(state_o) == 3'd1 && $past(state_o, 2) == 3'd1));

  // R4: RECOVERY is entered only after two cycles of EXITING
  a_r4_exit_dwell: assert property (@(posedge clk) disable iff (rst)
    (state_o == 3'd4 && $past(state_o) != 3'd4)
      |-> ($past(state_o) == 3'd3 && $past(state_o, 2) == 3'd3));

  // R6: gating and access enable never overlap
  a_r6_gate_excl: assert property (@(posedge clk) disable iff (rst)
    !(pwr_gate && access_en));

  // R7: abort is a single-cycle pulse raised on leaving ACTIVE
  a_r7_abort_pulse: assert property (@(posedge clk) disable iff (rst)
    access_abort |-> (state_o == 3'd1 && $past(state_o) == 3'd0));
  a_r7_abort_single: assert property (@(posedge clk) disable iff (rst)
    access_abort |=> !access_abort);

  // R8: selected-at-entry error is sticky
  a_r8_sel_err_sticky: assert property (@(posedge clk) disable iff (rst)
    sel_err |=> sel_err);

  // R9: wake-window violation is sticky
  a_r9_viol_sticky: assert property (@(posedge clk) disable iff (rst)
    recov_viol |=> recov_viol);

  // R3: state stays inside the encoded set
  a_r3_legal_state: assert property (@(posedge clk) disable iff (rst)
    state_o <= 3'd4);

endmodule

bind mem_sleep_ctrl mslp_chk u_chk (
  .clk          (clk),
  .rst          (rst),
  .state_o      (state_o),
  .pwr_gate     (pwr_gate),
  .access_en    (access_en),
  .access_abort (access_abort),
  .sel_err      (sel_err),
  .recov_viol   (recov_viol)
);

// File: tb/mem_sleep_ctrl_bench.sv
module mem_sleep_ctrl_bench;

  localparam int SYNC = 2;
  localparam int ENT  = 2;
  localparam int EXI  = 2;
  localparam int REC  = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sleep_req = 1'b0;
  logic chip_sel = 1'b0, astb_proc = 1'b0, astb_ctrl = 1'b0, access_busy = 1'b0;
  logic [2:0] state_o;
  logic pwr_gate, access_en, access_abort, sel_err, recov_viol;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  mem_sleep_ctrl #(
    .SYNC_STAGES(SYNC), .ENTER_CYCLES(ENT), .EXIT_CYCLES(EXI), .RECOV_CYCLES(REC)
  ) u_mem_sleep_ctrl (
    .clk(clk), .rst(rst), .sleep_req_async(sleep_req),
    .chip_sel(chip_sel), .astb_proc(astb_proc), .astb_ctrl(astb_ctrl),
    .access_busy(access_busy), .state_o(state_o), .pwr_gate(pwr_gate),
    .access_en(access_en), .access_abort(access_abort), .sel_err(sel_err),
    .recov_viol(recov_viol)
  );

  // Behavioural reference model, advanced on every rising edge
  bit sync_q[$];
  int m_st = 0, m_cnt = 0;
  bit m_abort = 0, m_selerr = 0, m_viol = 0;

  initial for (int i = 0; i < SYNC; i++) sync_q.push_back(1'b0);

  always @(posedge clk) begin
    if (rst) begin
      sync_q.delete();
      for (int i = 0; i < SYNC; i++) sync_q.push_back(1'b0);
      m_st = 0; m_cnt = 0; m_abort = 0; m_selerr = 0; m_viol = 0;
    end else begin
      bit rq;
      bit sel;
      bit nab;
      rq  = sync_q[0];
      sel = chip_sel | astb_proc | astb_ctrl;
      nab = 1'b0;
      case (m_st)
        0: if (rq) begin
             if (sel) m_selerr = 1;
             if (access_busy) nab = 1;
             m_st = 1; m_cnt = 0;
           end
        1: if (m_cnt == ENT - 1) begin m_st = 2; m_cnt = 0; end else m_cnt++;
        2: if (!rq) begin m_st = 3; m_cnt = 0; end
        3: begin
             if (sel) m_viol = 1;
             if (m_cnt == EXI - 1) begin m_st = 4; m_cnt = 0; end else m_cnt++;
           end
        default: begin
             if (sel) m_viol = 1;
             if (m_cnt == REC - 1) begin m_st = 0; m_cnt = 0; end else m_cnt++;
           end
      endcase
      m_abort = nab;
      void'(sync_q.pop_front());
      sync_q.push_back(sleep_req);
    end
  end

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Per-cycle comparison and dwell measurement, away from the active edge
  int prev_st = 0, run = 0;
  bit saw_abort = 0, saw_sleep = 0;

  always @(negedge clk) begin
    check("R3", "state_o", int'(state_o), m_st);
    check("R6", "pwr_gate", int'(pwr_gate), int'(m_st == 2));
    check("R6", "access_en", int'(access_en), int'(m_st == 0));
    check("R7", "access_abort", int'(access_abort), int'(m_abort));
    check("R8", "sel_err", int'(sel_err), int'(m_selerr));
    check("R9", "recov_viol", int'(recov_viol), int'(m_viol));
    if (access_abort) saw_abort = 1;
    if (state_o == 3'd2) saw_sleep = 1;
    if (rst) begin
      prev_st = 0; run = 0;
    end else if (int'(state_o) != prev_st) begin
      if (prev_st == 1) check("R3", "ENTERING dwell", run, ENT);
      if (prev_st == 3) check("R4", "EXITING dwell", run, EXI);
      if (prev_st == 4) check("R5", "RECOVERY dwell", run, REC);
      prev_st = int'(state_o); run = 1;
    end else run++;
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    rst = 1'b1; cyc(2); rst = 1'b0;
  endtask

  task automatic wait_active(input int limit);
    for (int i = 0; i < limit; i++) begin
      if (state_o == 3'd0) break;
      cyc(1);
    end
  endtask

  task automatic wait_state(input int s, input int limit);
    for (int i = 0; i < limit; i++) begin
      if (int'(state_o) == s) break;
      cyc(1);
    end
  endtask

  initial begin
    int edges;
    cyc(3);
    // R1: reset values
    check("R1", "reset state", int'(state_o), 0);
    check("R1", "reset access_en", int'(access_en), 1);
    check("R1", "reset flags", int'({access_abort, sel_err, recov_viol, pwr_gate}), 0);
    rst = 1'b0;

    // R10: no request, select activity in ACTIVE
    for (int i = 0; i < 6; i++) begin
      chip_sel = i[0]; astb_proc = i[1]; astb_ctrl = i[2]; cyc(1);
    end
    chip_sel = 0; astb_proc = 0; astb_ctrl = 0; cyc(1);
    check("R10", "idle state", int'(state_o), 0);
    check("R10", "idle flags", int'({sel_err, recov_viol}), 0);

    // R2: synchroniser latency, then clean sleep and wake
    sleep_req = 1'b1;
    edges = 0;
    for (int i = 0; i < 20; i++) begin
      cyc(1); edges++;
      if (state_o != 3'd0) break;
    end
    check("R2", "edges to leave ACTIVE", edges, SYNC + 1);
    cyc(8);
    check("R6", "gated while sleeping", int'(pwr_gate), 1);
    sleep_req = 1'b0;
    cyc(2);
    wait_active(40);
    check("R5", "back to ACTIVE", int'(state_o), 0);
    check("R9", "clean wake has no violation", int'(recov_viol), 0);

    // R7/R8: request while busy and selected
    do_reset();
    chip_sel = 1; access_busy = 1; sleep_req = 1;
    saw_abort = 0;
    cyc(4);
    chip_sel = 0; access_busy = 0;
    cyc(4);
    check("R7", "abort pulse seen", int'(saw_abort), 1);
    check("R8", "selected-at-entry error", int'(sel_err), 1);
    // R9: strobe during RECOVERY
    sleep_req = 0;
    wait_state(4, 40);
    astb_ctrl = 1; cyc(1); astb_ctrl = 0;
    wait_active(40);
    check("R9", "violation after RECOVERY strobe", int'(recov_viol), 1);
    check("R8", "error still held", int'(sel_err), 1);

    // R11: one-cycle request, plus strobe during EXITING
    do_reset();
    saw_sleep = 0;
    sleep_req = 1; cyc(1); sleep_req = 0;
    wait_state(3, 40);
    astb_proc = 1; cyc(1); astb_proc = 0;
    wait_active(40);
    check("R11", "short request still slept", int'(saw_sleep), 1);
    check("R9", "violation after EXITING strobe", int'(recov_viol), 1);
    check("R11", "returned to ACTIVE", int'(state_o), 0);

    cyc(3);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL R5 watchdog: actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule